// File: doc/BRIEF.md
# Balanced-Ternary Set/Reset Latch

This block is a clocked model of a three-level set/reset storage element. Each trit (minus, zero, plus) travels on a two-bit code. The block has two trit inputs, a set line and a reset line. It drives a trit output, the ternary inverse of that output, a flag that shows whether the stored value has been defined yet, and a flag for illegal input.

The block keeps no three-level register. It stores its value in two cells, and each cell holds only minus or plus. The first cell is read as it is. The second cell passes through a clamp that turns plus into zero. The output is the ternary maximum of the two results.

- A set trait of minus or plus loads the same level into both cells.
- A reset of plus loads minus into the plain cell and plus into the clamped cell, which gives a zero output.
- The reset line normally rests at minus, which means no reset. A zero on the reset line is illegal.

The block samples its inputs on each rising clock edge. The `rst_n` input only brings the model to a known start. After `rst_n`, the stored value counts as undefined until a first legal write.

Top module: `ternary_sr_latch`

## Requirements
- R1: Trits use the code 2'b00 for minus, 2'b01 for zero and 2'b10 for plus. With set at zero and reset at minus, the output keeps its previous value.
- R2: With set at minus and reset at minus, the output is minus after the next rising edge.
- R3: With set at plus and reset at minus, the output is plus after the next rising edge. Set can move the output straight from plus to minus, or from minus to plus, with no reset in between.
- R4: With reset at plus and set at any legal code, the output is zero after the next rising edge. Reset wins over set.
- R5: The output takes one of the three legal codes on every cycle after `rst_n`. It never takes 2'b11.
- R6: Any of the following is an illegal input: reset at zero, or code 2'b11 on either input. After an edge that samples an illegal input, `invalid_o` is 1 and both the output and `valid_o` keep their previous values. After an edge that samples a legal pair, `invalid_o` is 0.
- R7: `qn_o` is the ternary inverse of `q_o`. Minus and plus swap, and zero stays zero.
- R8: After `rst_n`, `valid_o` is 0 and `q_o` reads minus. `valid_o` becomes 1 after the first edge that samples a legal reset at plus or a legal nonzero set. It then stays 1 until the next `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous start of the model |
| set_i | input | 2 | Set trit |
| rst_trit_i | input | 2 | Reset trit; minus means idle |
| q_o | output | 2 | Stored trit |
| qn_o | output | 2 | Ternary inverse of `q_o` |
| valid_o | output | 1 | 1 once the stored value has been defined by a write |
| invalid_o | output | 1 | 1 when the last sampled input pair was illegal |

## Verification
A vector walk drives the latch through the following patterns:
- holds at each of the three levels;
- direct set swaps between plus and minus, which show that no reset is needed between them;
- resets combined with each legal set code, which expose the reset priority;
- illegal codes on each line, which must change nothing apart from the flag.

Directed tests start from `rst_n` and check three things:
- an illegal input leaves `valid_o` low;
- a hold leaves `valid_o` low;
- a reset alone raises `valid_o` with a zero output, which separates the defining write from the reset-default minus.

// File: rtl/ternary_sr_pkg.sv
package ternary_sr_pkg;

    localparam int TRIT_W = 2;

    typedef enum logic [TRIT_W-1:0] {
        T_NEG  = 2'b00,
        T_ZERO = 2'b01,
        T_POS  = 2'b10,
        T_BAD  = 2'b11
    } trit_e;

    localparam int N_CELLS = 2;
    localparam int CELL_PLAIN = 0;
    localparam int CELL_CLAMP = 1;

    // A cell bit of 1 stands for plus, 0 for minus
    function automatic logic [TRIT_W-1:0] t_from_bit(input logic b);
        return b ? T_POS : T_NEG;
    endfunction

    function automatic logic [TRIT_W-1:0] t_clamp(input logic [TRIT_W-1:0] a);
        return (a == T_POS) ? T_ZERO : a;
    endfunction

    function automatic logic [TRIT_W-1:0] t_max(input logic [TRIT_W-1:0] a,
                                                input logic [TRIT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [TRIT_W-1:0] t_inv(input logic [TRIT_W-1:0] a);
        case (a)
            T_NEG:   return T_POS;
            T_POS:   return T_NEG;
            default: return T_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/tsr_encoder.sv
module tsr_encoder
    import ternary_sr_pkg::*;
(
    input  logic [TRIT_W-1:0]  set_i,
    input  logic [TRIT_W-1:0]  rst_trit_i,
    output logic [N_CELLS-1:0] load_o,
    output logic [N_CELLS-1:0] val_o,
    output logic               bad_o,
    output logic               define_o
);
    logic set_bad, rst_bad;

    always_comb begin
        set_bad  = (set_i == T_BAD);
        rst_bad  = (rst_trit_i == T_BAD) || (rst_trit_i == T_ZERO);
        bad_o    = set_bad || rst_bad;
        load_o   = '0;
        val_o    = '0;
        define_o = 1'b0;
        if (!bad_o) begin
            if (rst_trit_i == T_POS) begin
                load_o             = '1;
                val_o[CELL_PLAIN]  = 1'b0;
                val_o[CELL_CLAMP]  = 1'b1;
                define_o           = 1'b1;
            end else if (set_i != T_ZERO) begin
                load_o   = '1;
                val_o    = {N_CELLS{set_i == T_POS}};
                define_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tsr_cell.sv
module tsr_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic val_i,
    output logic state_o
);
    typedef struct packed {
        logic level;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (load_i) cell_d.level = val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign state_o = cell_q.level;
endmodule

// File: rtl/tsr_merge.sv
module tsr_merge
    import ternary_sr_pkg::*;
(
    input  logic [N_CELLS-1:0] cells_i,
    output logic [TRIT_W-1:0]  q_o,
    output logic [TRIT_W-1:0]  qn_o
);
    logic [TRIT_W-1:0] plain_t, clamp_t;

    always_comb begin
        plain_t = t_from_bit(cells_i[CELL_PLAIN]);
        clamp_t = t_clamp(t_from_bit(cells_i[CELL_CLAMP]));
        q_o     = t_max(plain_t, clamp_t);
        qn_o    = t_inv(q_o);
    end
endmodule

// File: rtl/ternary_sr_latch.sv
module ternary_sr_latch
    import ternary_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIT_W-1:0] set_i,
    input  logic [TRIT_W-1:0] rst_trit_i,
    output logic [TRIT_W-1:0] q_o,
    output logic [TRIT_W-1:0] qn_o,
    output logic              valid_o,
    output logic              invalid_o
);
    typedef struct packed {
        logic valid;
        logic invalid;
    } flags_t;

    flags_t flg_d, flg_q;

    logic [N_CELLS-1:0] load, val, cells;
    logic               bad, define;

    tsr_encoder u_enc (
        .set_i      (set_i),
        .rst_trit_i (rst_trit_i),
        .load_o     (load),
        .val_o      (val),
        .bad_o      (bad),
        .define_o   (define)
    );

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        tsr_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load[g]),
            .val_i   (val[g]),
            .state_o (cells[g])
        );
    end

    tsr_merge u_merge (
        .cells_i (cells),
        .q_o     (q_o),
        .qn_o    (qn_o)
    );

    always_comb begin
        flg_d         = flg_q;
        flg_d.invalid = bad;
        if (define) flg_d.valid = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign valid_o   = flg_q.valid;
    assign invalid_o = flg_q.invalid;
endmodule

// File: rtl/ternary_sr_latch_chk.sv
module ternary_sr_latch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] set_i,
    input logic [1:0] rst_trit_i,
    input logic [1:0] q_o,
    input logic [1:0] qn_o,
    input logic       valid_o,
    input logic       invalid_o
);
    logic illegal;
    assign illegal = (set_i == 2'b11) || (rst_trit_i == 2'b11) || (rst_trit_i == 2'b01);

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == 2'b01 && rst_trit_i == 2'b00) |=> $stable(q_o));

    a_r2_minus: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == 2'b00 && rst_trit_i == 2'b00) |=> (q_o == 2'b00));

    a_r3_plus: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == 2'b10 && rst_trit_i == 2'b00) |=> (q_o == 2'b10));

    a_r4_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_trit_i == 2'b10 && set_i != 2'b11) |=> (q_o == 2'b01));

    a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        q_o != 2'b11);

    a_r6_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (invalid_o && $stable(q_o) && $stable(valid_o)));

    a_r6_invalid_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal |=> !invalid_o);

    a_r7_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o == 2'b01) ? (qn_o == 2'b01) : (qn_o == (q_o ^ 2'b10)));

    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    a_r8_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && (illegal || (set_i == 2'b01 && rst_trit_i == 2'b00))) |=> !valid_o);
endmodule

bind ternary_sr_latch ternary_sr_latch_chk u_chk (.*);

// File: tb/tb_ternary_sr_latch.sv
module tb_ternary_sr_latch;
    localparam logic [1:0] M = 2'b00, Z = 2'b01, P = 2'b10, X = 2'b11;
    localparam int NV = 16;

    // {set, reset, expected q, expected invalid, expected valid}
    localparam logic [7:0] VEC [NV] = '{
        {Z, M, M, 1'b0, 1'b0},   // R1 hold before any write, R8 stays low
        {P, M, P, 1'b0, 1'b1},   // R3, R8 rises
        {Z, M, P, 1'b0, 1'b1},   // R1 hold plus
        {M, M, M, 1'b0, 1'b1},   // R3 swap plus->minus, R2
        {P, M, P, 1'b0, 1'b1},   // R3 swap minus->plus
        {Z, P, Z, 1'b0, 1'b1},   // R4
        {Z, M, Z, 1'b0, 1'b1},   // R1 hold zero
        {P, P, Z, 1'b0, 1'b1},   // R4 priority over plus
        {M, Z, Z, 1'b1, 1'b1},   // R6 reset zero
        {Z, M, Z, 1'b0, 1'b1},   // R6 flag clears
        {X, M, Z, 1'b1, 1'b1},   // R6 illegal set
        {M, M, M, 1'b0, 1'b1},   // R2
        {M, P, Z, 1'b0, 1'b1},   // R4 priority over minus
        {P, X, Z, 1'b1, 1'b1},   // R6 illegal reset
        {P, M, P, 1'b0, 1'b1},   // R3
        {Z, Z, P, 1'b1, 1'b1}    // R6 hold plus
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] set_i = Z, rst_trit_i = M;
    logic [1:0] q_o, qn_o;
    logic valid_o, invalid_o;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    ternary_sr_latch dut (.*);

    function automatic logic [1:0] inv(input logic [1:0] a);
        return (a == M) ? P : (a == P) ? M : Z;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic [1:0] r);
        @(negedge clk);
        set_i = s; rst_trit_i = r;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; set_i = Z; rst_trit_i = M;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
    endtask

    initial begin : watchdog
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R8 reset q", {2'b00, q_o}, {2'b00, M});
        check("R8 reset valid", {3'b0, valid_o}, 4'd0);
        check("R7 reset qn", {2'b00, qn_o}, {2'b00, P});

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][7:6], VEC[i][5:4]);
            check("R1-R4 q", {2'b00, q_o}, {2'b00, VEC[i][3:2]});
            check("R7 qn", {2'b00, qn_o}, {2'b00, inv(VEC[i][3:2])});
            check("R6 invalid", {3'b0, invalid_o}, {3'b0, VEC[i][1]});
            check("R8 valid", {3'b0, valid_o}, {3'b0, VEC[i][0]});
        end

        // R8: an illegal input after reset does not define the value
        do_reset();
        apply(P, Z);
        check("R8 illegal keeps undefined", {3'b0, valid_o}, 4'd0);
        check("R6 illegal holds q", {2'b00, q_o}, {2'b00, M});

        // R8 and R4: reset alone defines the value as zero
        apply(Z, P);
        check("R8 reset defines", {3'b0, valid_o}, 4'd1);
        check("R4 reset gives zero", {2'b00, q_o}, {2'b00, Z});

        // R8: a set of minus defines without moving q
        do_reset();
        apply(M, M);
        check("R8 minus defines", {3'b0, valid_o}, 4'd1);
        check("R2 minus after reset", {2'b00, q_o}, {2'b00, M});

        // R5: the output stays a legal code
        check("R5 legal code", {3'b0, q_o == X}, 4'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule